// File: doc/BRIEF.md
# DMA Channel Control Core

This block is the per-channel control core of a simple DMA engine. It holds a source address, a destination address, a byte count, a control word and a set of sticky status flags, all reached through a small word-indexed register port. A start request arms the channel. The block first checks the programmed addresses, port sizes and count against each other. If they are consistent, it enters the busy state and presents the operand step for each transfer. The bus master beside it runs the actual cycles and reports completion, bus errors and breakpoints back through strobes.

After each completed operand, the core advances each address whose increment bit is set and lowers the remaining count. The step is the largest of 1, 2 or 4 bytes that three things allow: the operand size, the current alignment of both addresses, and the bytes still left. When the count reaches zero the channel raises its done flag and returns to idle. The done flag and every error flag are sticky and clear only by writing ones to them. While any of them is set, the channel refuses to start again. The address registers are not touched by reset, and their contents survive a reset.

Top module: `dma_chan_core`

## Requirements
- R1: After reset the status flags, the control word and the count read as zero, and the channel is idle (busy low).
- R2: Status register (offset 1) holds sticky flags at bit 6 done, bit 5 source bus error, bit 4 destination bus error, bit 3 configuration error and bit 2 breakpoint; bits 7, 1 and 0 read zero. Writing a one to a flag bit clears that flag, writing a zero leaves it, and writing 0x7C clears all five.
- R3: A start request is ignored, and the channel stays idle, while any status flag is set, while the channel is halted, or while it is already busy.
- R4: On an accepted start, a configuration error is flagged and the channel stays idle if: either address is misaligned to its port size, AND the count is zero or is not a multiple of the larger of the two port sizes.
- R5: An accepted start with no configuration error and a nonzero count makes the channel busy on the next cycle; with a zero count it sets done at once and stays idle.
- R6: Control word (offset 0): bit 0 halt, bit 1 source increment, bit 2 destination increment, bits 4:3 source port size, bits 6:5 destination port size, bits 8:7 operand size (0 byte, 1 word, 2 long). The step output is the smallest of four limits: the operand size, the alignment of the source address, the alignment of the destination address, and the largest of 1, 2 or 4 not above the count. Byte operands therefore always step by 1.
- R7: On each completed transfer an address whose increment bit is set advances by the step with unsigned wrap (0xFFFFFFFF becomes 0x00000000); an address whose bit is clear holds.
- R8: The count (offset 4) drops by the step on each completed transfer; the transfer that brings it to zero sets done and returns the channel to idle.
- R9: A source or destination bus error strobe while busy sets the matching flag, stops the channel and leaves addresses and count unchanged.
- R10: A breakpoint strobe while busy sets the breakpoint flag without stopping the channel.
- R11: While halt is set, source (offset 2) and destination (offset 3) read zero and writes to them are ignored; clearing halt restores access to the held values.
- R12: Writes to the control, address and count registers are ignored while the channel is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| start_req | input | 1 | Start request pulse |
| xfer_done | input | 1 | One operand transfer completed |
| bus_err_src | input | 1 | Bus error on the source cycle |
| bus_err_dst | input | 1 | Bus error on the destination cycle |
| brkpt | input | 1 | Breakpoint indication |
| busy | output | 1 | Channel is transferring |
| step_bytes | output | 3 | Byte size of the next operand (1, 2 or 4) |
| src_addr | output | ADDR_W | Current source address |
| dst_addr | output | ADDR_W | Current destination address |

## Verification
The bench builds the block with its default 32-bit addresses and a 16-bit count. At that size the unsigned wrap of an address from all ones to zero can be reached directly. The count cap on the step is exercised with counts of 3 and 7. A vector table sweeps mixed port sizes, odd and even addresses and counts that do or do not divide the larger port. The same sweep covers the zero-count case both with and without misalignment.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_WORD = 2'd1,
      SZ_LONG = 2'd2,
      SZ_RSVD = 2'd3
   } sz_e;

   // register word indices
   localparam logic [2:0] RA_CTRL = 3'd0;
   localparam logic [2:0] RA_STAT = 3'd1;
   localparam logic [2:0] RA_SRC  = 3'd2;
   localparam logic [2:0] RA_DST  = 3'd3;
   localparam logic [2:0] RA_CNT  = 3'd4;

   // sticky flag indices; status bit = index + FLAG_LSB
   localparam int FLAG_N   = 5;
   localparam int FLAG_LSB = 2;
   localparam int FL_BRKP  = 0;
   localparam int FL_CONF  = 1;
   localparam int FL_BED   = 2;
   localparam int FL_BES   = 3;
   localparam int FL_DONE  = 4;

   localparam int CTRL_W = 9;

   typedef struct packed {
      sz_e  op_sz;
      sz_e  dst_ps;
      sz_e  src_ps;
      logic dst_inc;
      logic src_inc;
      logic halt;
   } ctrl_t;

   // log2 of the byte size; reserved code behaves as long
   function automatic logic [1:0] sz_log2(input sz_e s);
      case (s)
         SZ_BYTE: sz_log2 = 2'd0;
         SZ_WORD: sz_log2 = 2'd1;
         default: sz_log2 = 2'd2;
      endcase
   endfunction

   // log2 of the natural alignment of an address, capped at 4 bytes
   function automatic logic [1:0] align_log2(input logic [1:0] lo);
      if (lo[0])      align_log2 = 2'd0;
      else if (lo[1]) align_log2 = 2'd1;
      else            align_log2 = 2'd2;
   endfunction

   function automatic logic [1:0] min_log2(input logic [1:0] a, input logic [1:0] b);
      min_log2 = (a < b) ? a : b;
   endfunction

endpackage

// File: rtl/dma_step_calc.sv
module dma_step_calc
   import dma_chan_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  sz_e              op_sz,
   input  logic [1:0]       src_lo,
   input  logic [1:0]       dst_lo,
   input  logic [CNT_W-1:0] cnt,
   output logic [2:0]       step_bytes
);
   logic [1:0] cnt_lim;
   logic [1:0] addr_lim;
   logic [1:0] step_l2;

   always_comb begin
      if (cnt >= CNT_W'(4))      cnt_lim = 2'd2;
      else if (cnt >= CNT_W'(2)) cnt_lim = 2'd1;
      else                       cnt_lim = 2'd0;
      addr_lim = min_log2(align_log2(src_lo), align_log2(dst_lo));
      step_l2  = min_log2(min_log2(sz_log2(op_sz), addr_lim), cnt_lim);
      step_bytes = 3'd1 << step_l2;
   end

   // R6: byte operands never take a wider step
   always_comb begin
      if (op_sz == SZ_BYTE)
         a_byte_step_r6: assert (step_bytes == 3'd1 || $isunknown(step_bytes));
   end
endmodule

// File: rtl/dma_cfg_check.sv
module dma_cfg_check
   import dma_chan_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  sz_e              src_ps,
   input  sz_e              dst_ps,
   input  logic [1:0]       src_lo,
   input  logic [1:0]       dst_lo,
   input  logic [CNT_W-1:0] cnt,
   output logic             cfg_err
);
   logic [1:0] src_l2, dst_l2, big_l2;
   logic [1:0] src_mask, dst_mask, big_mask;
   logic       misaligned, cnt_bad;

   always_comb begin
      src_l2   = sz_log2(src_ps);
      dst_l2   = sz_log2(dst_ps);
      big_l2   = (src_l2 > dst_l2) ? src_l2 : dst_l2;
      src_mask = 2'((3'd1 << src_l2) - 3'd1);
      dst_mask = 2'((3'd1 << dst_l2) - 3'd1);
      big_mask = 2'((3'd1 << big_l2) - 3'd1);
      misaligned = |(src_lo & src_mask) || |(dst_lo & dst_mask);
      cnt_bad    = (cnt == '0) || |(cnt[1:0] & big_mask);
      cfg_err    = misaligned && cnt_bad;
   end
endmodule

// File: rtl/dma_flag_bank.sv
module dma_flag_bank #(
   parameter int N = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic [N-1:0] clr,
   output logic [N-1:0] q
);
   for (genvar i = 0; i < N; i++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      q[i] <= 1'b0;
         else if (set[i]) q[i] <= 1'b1;
         else if (clr[i]) q[i] <= 1'b0;
      end

      // R2: a flag only drops on a write of one to its bit
      p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (q[i] && !clr[i]) |=> q[i]);
      p_set_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
         set[i] |=> q[i]);
   end
endmodule

// File: rtl/dma_addr_reg.sv
module dma_addr_reg #(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_data,
   input  logic              adv,
   input  logic              inc,
   input  logic [2:0]        step,
   output logic [ADDR_W-1:0] q
);
   // deliberately outside reset: contents survive a reset
   always_ff @(posedge clk) begin
      if (wr_en)           q <= wr_data;
      else if (adv && inc) q <= q + ADDR_W'(step);
   end

   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !inc && !wr_en) |=> $stable(q));
   p_adv_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && inc && !wr_en) |=> (q == ADDR_W'($past(q) + ADDR_W'($past(step)))));
endmodule

// File: rtl/dma_chan_core.sv
module dma_chan_core
   import dma_chan_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [2:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              start_req,
   input  logic              xfer_done,
   input  logic              bus_err_src,
   input  logic              bus_err_dst,
   input  logic              brkpt,
   output logic              busy,
   output logic [2:0]        step_bytes,
   output logic [ADDR_W-1:0] src_addr,
   output logic [ADDR_W-1:0] dst_addr
);
   localparam int N_ADDR = 2;   // 0 source, 1 destination

   if (ADDR_W < 8 || ADDR_W > 32) begin : g_bad_aw
      $error("dma_chan_core: ADDR_W must lie in 8..32");
   end
   if (CNT_W < 3 || CNT_W > 32) begin : g_bad_cw
      $error("dma_chan_core: CNT_W must lie in 3..32");
   end

   ctrl_t             ctrl_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              busy_q;
   logic [FLAG_N-1:0] flags_q, flag_set, flag_clr;
   logic [ADDR_W-1:0] addr_q [N_ADDR];
   logic [N_ADDR-1:0] addr_wr, addr_inc;
   logic              cfg_err, start_ok, start_go, start_zero;
   logic              adv, last, any_err;
   logic [CNT_W-1:0]  step_c;

   assign src_addr = addr_q[0];
   assign dst_addr = addr_q[1];
   assign busy     = busy_q;
   assign step_c   = CNT_W'(step_bytes);

   // register writes
   logic wr_ctrl, wr_cnt, wr_stat;
   always_comb begin
      wr_ctrl    = reg_wr && reg_addr == RA_CTRL && !busy_q;
      wr_cnt     = reg_wr && reg_addr == RA_CNT  && !busy_q;
      wr_stat    = reg_wr && reg_addr == RA_STAT;
      addr_wr[0] = reg_wr && reg_addr == RA_SRC && !busy_q && !ctrl_q.halt;
      addr_wr[1] = reg_wr && reg_addr == RA_DST && !busy_q && !ctrl_q.halt;
      addr_inc[0] = ctrl_q.src_inc;
      addr_inc[1] = ctrl_q.dst_inc;
   end

   // sequencing
   always_comb begin
      any_err    = bus_err_src || bus_err_dst;
      start_ok   = start_req && !busy_q && !ctrl_q.halt && (flags_q == '0);
      start_go   = start_ok && !cfg_err && (cnt_q != '0);
      start_zero = start_ok && !cfg_err && (cnt_q == '0);
      adv        = busy_q && xfer_done && !any_err;
      last       = adv && (cnt_q == step_c);
   end

   always_comb begin
      flag_set          = '0;
      flag_set[FL_DONE] = last || start_zero;
      flag_set[FL_BES]  = busy_q && bus_err_src;
      flag_set[FL_BED]  = busy_q && bus_err_dst;
      flag_set[FL_CONF] = start_ok && cfg_err;
      flag_set[FL_BRKP] = busy_q && brkpt;
      flag_clr = wr_stat ? reg_wdata[FLAG_LSB +: FLAG_N] : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         cnt_q  <= '0;
         busy_q <= 1'b0;
      end else begin
         if (wr_ctrl) ctrl_q <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
         if (wr_cnt)   cnt_q <= reg_wdata[CNT_W-1:0];
         else if (adv) cnt_q <= cnt_q - step_c;
         if (start_go) busy_q <= 1'b1;
         else if (busy_q && (last || any_err)) busy_q <= 1'b0;
      end
   end

   dma_flag_bank #(.N(FLAG_N)) u_flags (
      .clk(clk), .rst_n(rst_n), .set(flag_set), .clr(flag_clr), .q(flags_q)
   );

   for (genvar a = 0; a < N_ADDR; a++) begin : g_addr
      dma_addr_reg #(.ADDR_W(ADDR_W)) u_addr (
         .clk(clk), .rst_n(rst_n), .wr_en(addr_wr[a]), .wr_data(reg_wdata[ADDR_W-1:0]),
         .adv(adv), .inc(addr_inc[a]), .step(step_bytes), .q(addr_q[a])
      );
   end

   dma_cfg_check #(.CNT_W(CNT_W)) u_cfg (
      .src_ps(ctrl_q.src_ps), .dst_ps(ctrl_q.dst_ps),
      .src_lo(addr_q[0][1:0]), .dst_lo(addr_q[1][1:0]),
      .cnt(cnt_q), .cfg_err(cfg_err)
   );

   dma_step_calc #(.CNT_W(CNT_W)) u_step (
      .op_sz(ctrl_q.op_sz), .src_lo(addr_q[0][1:0]), .dst_lo(addr_q[1][1:0]),
      .cnt(cnt_q), .step_bytes(step_bytes)
   );

   // read path
   always_comb begin
      case (reg_addr)
         RA_CTRL: reg_rdata = 32'(ctrl_q);
         RA_STAT: reg_rdata = 32'({flags_q, {FLAG_LSB{1'b0}}});
         RA_SRC:  reg_rdata = ctrl_q.halt ? '0 : 32'(addr_q[0]);
         RA_DST:  reg_rdata = ctrl_q.halt ? '0 : 32'(addr_q[1]);
         RA_CNT:  reg_rdata = 32'(cnt_q);
         default: reg_rdata = '0;
      endcase
   end

   p_start_blocked_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (start_req && !busy_q && (flags_q != '0)) |=> !busy_q);
   p_conf_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (start_ok && cfg_err) |=> (flags_q[FL_CONF] && !busy_q));
   p_step_pow2_r6: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> ($countones(step_bytes) == 1));
   p_done_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
      last |=> (!busy_q && flags_q[FL_DONE] && cnt_q == '0));
   p_err_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && any_err) |=> (!busy_q && $stable(cnt_q)));
   p_brk_run_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && brkpt && !any_err && !last) |=> (busy_q && flags_q[FL_BRKP]));
   p_busy_lock_r12: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |=> $stable(ctrl_q));
endmodule

// File: tb/dma_chan_core_bench.sv
module dma_chan_core_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        start_req = 1'b0, xfer_done = 1'b0;
   logic        bus_err_src = 1'b0, bus_err_dst = 1'b0, brkpt = 1'b0;
   logic        busy;
   logic [2:0]  step_bytes;
   logic [31:0] src_addr, dst_addr;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   dma_chan_core u_dma_chan_core (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .start_req(start_req),
      .xfer_done(xfer_done), .bus_err_src(bus_err_src), .bus_err_dst(bus_err_dst),
      .brkpt(brkpt), .busy(busy), .step_bytes(step_bytes),
      .src_addr(src_addr), .dst_addr(dst_addr)
   );

   typedef struct packed {
      logic [31:0] src;
      logic [31:0] dst;
      logic [15:0] ctrl;
      logic [15:0] cnt;
      logic [7:0]  exp_stat;
      logic        exp_busy;
   } vec_t;

   // R4/R5 sweep: ctrl bits 4:3 src port, 6:5 dst port, 8:7 operand size
   localparam vec_t VECS [8] = '{
      '{32'h100, 32'h200, 16'h156, 16'd16, 8'h00, 1'b1},
      '{32'h101, 32'h200, 16'h14E, 16'd16, 8'h00, 1'b1},
      '{32'h101, 32'h200, 16'h14E, 16'd6,  8'h08, 1'b0},
      '{32'h100, 32'h202, 16'h146, 16'd8,  8'h00, 1'b1},
      '{32'h103, 32'h200, 16'h0AE, 16'd0,  8'h08, 1'b0},
      '{32'h100, 32'h200, 16'h156, 16'd0,  8'h40, 1'b0},
      '{32'h100, 32'h201, 16'h136, 16'd16, 8'h00, 1'b1},
      '{32'h102, 32'h200, 16'h116, 16'd10, 8'h08, 1'b0}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic pulse_start();
      start_req = 1'b1; @(negedge clk); start_req = 1'b0;
   endtask
   task automatic pulse_xfer();
      xfer_done = 1'b1; @(negedge clk); xfer_done = 1'b0;
   endtask

   task automatic setup(input logic [31:0] s, input logic [31:0] d,
                        input logic [31:0] c, input logic [31:0] n);
      wr(3'd2, s); wr(3'd3, d); wr(3'd4, n); wr(3'd0, c);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(3'd1, v); chk("R1 status", v, 32'h0);
      rd(3'd0, v); chk("R1 ctrl", v, 32'h0);
      rd(3'd4, v); chk("R1 count", v, 32'h0);
      chk("R1 busy", {31'b0, busy}, 32'h0);

      // R4/R5 configuration sweep
      for (int i = 0; i < 8; i++) begin
         setup(VECS[i].src, VECS[i].dst, 32'(VECS[i].ctrl), 32'(VECS[i].cnt));
         pulse_start();
         rd(3'd1, v); chk($sformatf("R4 vec%0d status", i), v, 32'(VECS[i].exp_stat));
         chk($sformatf("R5 vec%0d busy", i), {31'b0, busy}, {31'b0, VECS[i].exp_busy});
         if (busy) begin
            bus_err_src = 1'b1; @(negedge clk); bus_err_src = 1'b0;
         end
         wr(3'd1, 32'h7C);
      end

      // R6/R7/R8 step sequence 1,2,4 with odd start addresses
      setup(32'h1001, 32'h2001, 32'h106, 32'd7);
      pulse_start();
      chk("R6 step odd", 32'(step_bytes), 32'd1);
      pulse_xfer();
      chk("R7 src+1", src_addr, 32'h1002);
      chk("R7 dst+1", dst_addr, 32'h2002);
      rd(3'd4, v); chk("R8 count 6", v, 32'd6);
      chk("R6 step even", 32'(step_bytes), 32'd2);
      pulse_xfer();
      chk("R6 step aligned", 32'(step_bytes), 32'd4);
      pulse_xfer();
      chk("R7 src end", src_addr, 32'h1008);
      chk("R8 idle at zero", {31'b0, busy}, 32'h0);
      rd(3'd1, v); chk("R8 done flag", v, 32'h40);
      wr(3'd1, 32'h7C);

      // R6 count caps the step
      setup(32'h3000, 32'h4000, 32'h106, 32'd3);
      pulse_start();
      chk("R6 count cap 2", 32'(step_bytes), 32'd2);
      pulse_xfer();
      chk("R6 count cap 1", 32'(step_bytes), 32'd1);
      pulse_xfer();
      rd(3'd1, v); chk("R8 done after cap", v, 32'h40);
      wr(3'd1, 32'h7C);

      // R6 byte operand, R9 destination bus error
      setup(32'h3000, 32'h4000, 32'h006, 32'd4);
      pulse_start();
      chk("R6 byte step", 32'(step_bytes), 32'd1);
      bus_err_dst = 1'b1; xfer_done = 1'b1; @(negedge clk);
      bus_err_dst = 1'b0; xfer_done = 1'b0;
      rd(3'd1, v); chk("R9 dst error flag", v, 32'h10);
      chk("R9 stopped", {31'b0, busy}, 32'h0);
      chk("R9 src held", src_addr, 32'h3000);
      rd(3'd4, v); chk("R9 count held", v, 32'd4);
      wr(3'd1, 32'h7C);

      // R7 wrap and constant source, R10 breakpoint, R12 busy lock
      setup(32'h5000, 32'hFFFF_FFFF, 32'h004, 32'd2);
      pulse_start();
      pulse_xfer();
      chk("R7 wrap", dst_addr, 32'h0);
      chk("R7 src const", src_addr, 32'h5000);
      wr(3'd0, 32'h1);
      rd(3'd0, v); chk("R12 ctrl locked", v, 32'h004);
      brkpt = 1'b1; @(negedge clk); brkpt = 1'b0;
      rd(3'd1, v); chk("R10 brk flag", v, 32'h04);
      chk("R10 still busy", {31'b0, busy}, 32'h1);
      pulse_xfer();
      rd(3'd1, v); chk("R8 done with brk", v, 32'h44);

      // R2 write-one-to-clear, R3 blocked start
      wr(3'd1, 32'h40);
      rd(3'd1, v); chk("R2 clear done only", v, 32'h04);
      wr(3'd1, 32'h0);
      rd(3'd1, v); chk("R2 zero no effect", v, 32'h04);
      wr(3'd4, 32'd8);
      pulse_start();
      chk("R3 start blocked", {31'b0, busy}, 32'h0);
      wr(3'd1, 32'hFFFF_FFFF);
      rd(3'd1, v); chk("R2 reserved zero", v, 32'h0);

      // R11 halt gates address access
      wr(3'd3, 32'hABCD_0000);
      wr(3'd0, 32'h1);
      wr(3'd3, 32'h1234);
      rd(3'd3, v); chk("R11 halted read", v, 32'h0);
      pulse_start();
      chk("R3 halted start", {31'b0, busy}, 32'h0);
      wr(3'd0, 32'h0);
      rd(3'd3, v); chk("R11 write ignored", v, 32'hABCD_0000);

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule